// File: doc/BRIEF.md
# Drive-Board Auxiliary Bus Latch and Status Combiner

This block sits on the drive-interface board next to a disk controller. The controller publishes two output bytes on a shared auxiliary bus and picks the destination with a two-bit select code. The block holds each byte in its own latch. The first latch drives the drive-select lines and four programmable outputs. The second latch drives the head number, a reduced-write-current level and the step direction. Each load of the second latch also produces a single step pulse for the floppy drive.

The block also builds the drive-status byte that goes back to the controller. It takes the index, track-zero, write-protect and fault lines from the cabling. It takes ready and seek-complete from the hard-disk lines, and it fills in those two bits itself when a floppy is selected or when the selected hard-disk unit is not fitted. The status byte is registered. A one-cycle flag marks the byte as freshly presented after every latch load.

Top module: `auxbus_latch`

## Requirements
- R1: While reset is asserted and after it is released, both latches read zero, the status byte is 0x00, the status flag is low, the step output is high and the direction output is high.
- R2: A strobe with select code 2'b01 loads the data byte into the first latch. Data bits 7:4 appear on the drive-select outputs and bits 3:0 on the programmable outputs, starting in the cycle after the strobe edge.
- R3: A strobe with select code 2'b11 loads the second latch. Data bits 3:0 appear as the head number and data bit 6 as the reduced-current level, starting in the cycle after the strobe edge.
- R4: A strobe with select code 2'b00 or 2'b10 changes no output. It produces no step pulse and no status flag.
- R5: Every load of the second latch makes the active-low step output go low for exactly one cycle, one cycle after the cycle in which the latch changes.
- R6: The direction output is the inverse of data bit 5 of the second latch. It changes in the same cycle as the latch, one cycle before the step pulse.
- R7: When drive-select bit 4 (the floppy select) is set, status bits 5 (seek complete) and 1 (ready) read 1, whatever the hard-disk select bits hold.
- R8: Status bits 7 and 3 always read 0. Bit 6 carries the index line, bit 4 track zero, bit 2 write protect and bit 0 fault.
- R9: With bit 4 clear and exactly one of drive-select bits 7:5 set, hard-disk unit 0, 1 or 2 is selected (bit 5, 6 or 7). If that unit's present line is high, status bits 1 and 5 follow the hard-disk ready and seek-complete lines. If the unit is absent, both bits read 1.
- R10: When no drive is selected (bits 7:4 all zero, or bit 4 clear and more than one of bits 7:5 set), the status byte is 0x00.
- R11: The status byte is registered. It reflects the drive lines and the first latch as they stood one cycle earlier.
- R12: The status flag is high for exactly one cycle: the second cycle after any strobe with code 2'b01 or 2'b11. In that cycle the status byte already reflects the new latch contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| abData | input | 8 | Auxiliary bus data byte |
| abSel | input | 2 | Destination select code |
| abStrobe | input | 1 | Write strobe, one cycle per byte |
| idxIn | input | 1 | Index line of the selected drive |
| trk0In | input | 1 | Track-zero line |
| wrProtIn | input | 1 | Write-protect line |
| faultIn | input | 1 | Fault line |
| hdPresent | input | NUM_HD | Per-unit hard-disk fitted flags |
| hdReadyIn | input | 1 | Ready line of the selected hard disk |
| hdSeekDoneIn | input | 1 | Seek-complete line of the selected hard disk |
| driveSel | output | 4 | Drive-select lines (first latch bits 7:4) |
| progOut | output | 4 | Programmable outputs (first latch bits 3:0) |
| headOut | output | 4 | Head number |
| wrCurOut | output | 1 | Reduced write current |
| dirOut | output | 1 | Step direction, inverted latch bit |
| stepN | output | 1 | Step pulse, active low |
| statusOut | output | 8 | Drive-status byte to the controller |
| statusValid | output | 1 | Status freshly presented after a latch load |

## Verification
The assertions assume that the controller never loads the second latch in two strobes closer than three cycles apart. With closer loads the step pulse would merge with the next one and the direction would change during a pulse. The stimulus always leaves at least two idle cycles after each strobe. The assertions also assume that drive lines change only between clock edges. The bench drives every input on the falling edge, and its reference model samples on the rising edge. This keeps the one-cycle status latency well defined while the drive lines toggle freely during the randomised phase.

// File: rtl/auxbus_pkg.sv
package auxbus_pkg;
  localparam logic [1:0] SEL_OUT1 = 2'b01;
  localparam logic [1:0] SEL_OUT2 = 2'b11;

  localparam int BYTE_W     = 8;
  localparam int NIB_W      = 4;
  localparam int FLOPPY_BIT = 4;
  localparam int HD_LSB     = FLOPPY_BIT + 1;

  // status byte bit positions (decoded by the controller)
  localparam int ST_INDEX = 6;
  localparam int ST_SEEK  = 5;
  localparam int ST_TRK0  = 4;
  localparam int ST_WPROT = 2;
  localparam int ST_READY = 1;
  localparam int ST_FAULT = 0;

  // second-latch field positions in the bus byte
  localparam int O2_WCUR = 6;
  localparam int O2_DIR  = 5;

  typedef struct packed {
    logic loadOut1;
    logic loadOut2;
    logic stepFire;
    logic pushStatus;
  } auxStrobes_t;

  typedef struct packed {
    logic             wCur;
    logic             dirBit;
    logic [NIB_W-1:0] head;
  } out2Latch_t;
endpackage

// File: rtl/auxbus_ctrl.sv
module auxbus_ctrl
  import auxbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        abStrobe,
  input  logic [1:0]  abSel,
  output auxStrobes_t strobes
);
  logic load1;
  logic load2;
  logic fireQ;
  logic pushQ;

  assign load1 = abStrobe && (abSel == SEL_OUT1);
  assign load2 = abStrobe && (abSel == SEL_OUT2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fireQ <= 1'b0;
      pushQ <= 1'b0;
    end else begin
      fireQ <= load2;
      pushQ <= load1 || load2;
    end
  end

  assign strobes.loadOut1   = load1;
  assign strobes.loadOut2   = load2;
  assign strobes.stepFire   = fireQ;
  assign strobes.pushStatus = pushQ;
endmodule

// File: rtl/auxbus_datapath.sv
module auxbus_datapath
  import auxbus_pkg::*;
#(
  parameter int NUM_HD = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  auxStrobes_t        strobes,
  input  logic [BYTE_W-1:0]  abData,
  input  logic               idxIn,
  input  logic               trk0In,
  input  logic               wrProtIn,
  input  logic               faultIn,
  input  logic [NUM_HD-1:0]  hdPresent,
  input  logic               hdReadyIn,
  input  logic               hdSeekDoneIn,
  output logic [BYTE_W-1:0]  out1Q,
  output out2Latch_t         out2Q,
  output logic               stepNQ,
  output logic [BYTE_W-1:0]  statusQ,
  output logic               validQ
);
  logic [NUM_HD-1:0] hdBits;
  logic [NUM_HD-1:0] hdHit;
  logic              floppySel;
  logic              hdSingle;
  logic              hdFitted;
  logic              anySel;
  logic              forceReady;
  logic [BYTE_W-1:0] statusNext;

  // output latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      out1Q <= '0;
      out2Q <= '0;
    end else begin
      if (strobes.loadOut1) out1Q <= abData;
      if (strobes.loadOut2) begin
        out2Q.wCur   <= abData[O2_WCUR];
        out2Q.dirBit <= abData[O2_DIR];
        out2Q.head   <= abData[NIB_W-1:0];
      end
    end
  end

  // hard-disk unit decode, one presence gate per unit
  assign hdBits = out1Q[HD_LSB +: NUM_HD];
  genvar u;
  generate
    for (u = 0; u < NUM_HD; u++) begin : g_unit
      assign hdHit[u] = hdBits[u] && hdPresent[u];
    end
  endgenerate

  assign floppySel  = out1Q[FLOPPY_BIT];
  assign hdSingle   = $onehot(hdBits);
  assign hdFitted   = |hdHit;
  assign anySel     = floppySel || hdSingle;
  assign forceReady = floppySel || !hdFitted;

  always_comb begin
    statusNext = '0;
    if (anySel) begin
      statusNext[ST_INDEX] = idxIn;
      statusNext[ST_TRK0]  = trk0In;
      statusNext[ST_WPROT] = wrProtIn;
      statusNext[ST_FAULT] = faultIn;
      statusNext[ST_READY] = forceReady ? 1'b1 : hdReadyIn;
      statusNext[ST_SEEK]  = forceReady ? 1'b1 : hdSeekDoneIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      validQ  <= 1'b0;
      stepNQ  <= 1'b1;
    end else begin
      statusQ <= statusNext;
      validQ  <= strobes.pushStatus;
      stepNQ  <= !strobes.stepFire;
    end
  end
endmodule

// File: rtl/auxbus_latch.sv
module auxbus_latch
  import auxbus_pkg::*;
#(
  parameter int NUM_HD = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        abData,
  input  logic [1:0]        abSel,
  input  logic              abStrobe,
  input  logic              idxIn,
  input  logic              trk0In,
  input  logic              wrProtIn,
  input  logic              faultIn,
  input  logic [NUM_HD-1:0] hdPresent,
  input  logic              hdReadyIn,
  input  logic              hdSeekDoneIn,
  output logic [3:0]        driveSel,
  output logic [3:0]        progOut,
  output logic [3:0]        headOut,
  output logic              wrCurOut,
  output logic              dirOut,
  output logic              stepN,
  output logic [7:0]        statusOut,
  output logic              statusValid
);
  auxStrobes_t       strobes;
  logic [BYTE_W-1:0] out1Q;
  out2Latch_t        out2Q;

  auxbus_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .abStrobe (abStrobe),
    .abSel    (abSel),
    .strobes  (strobes)
  );

  auxbus_datapath #(.NUM_HD(NUM_HD)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .abData       (abData),
    .idxIn        (idxIn),
    .trk0In       (trk0In),
    .wrProtIn     (wrProtIn),
    .faultIn      (faultIn),
    .hdPresent    (hdPresent),
    .hdReadyIn    (hdReadyIn),
    .hdSeekDoneIn (hdSeekDoneIn),
    .out1Q        (out1Q),
    .out2Q        (out2Q),
    .stepNQ       (stepN),
    .statusQ      (statusOut),
    .validQ       (statusValid)
  );

  assign driveSel = out1Q[BYTE_W-1:NIB_W];
  assign progOut  = out1Q[NIB_W-1:0];
  assign headOut  = out2Q.head;
  assign wrCurOut = out2Q.wCur;
  assign dirOut   = !out2Q.dirBit;
endmodule

// File: rtl/auxbus_chk.sv
module auxbus_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] abData,
  input logic [1:0] abSel,
  input logic       abStrobe,
  input logic [3:0] driveSel,
  input logic [3:0] progOut,
  input logic [3:0] headOut,
  input logic       dirOut,
  input logic       stepN,
  input logic [7:0] statusOut,
  input logic       statusValid
);
  a_r5_step_after_load: assert property (@(posedge clk) disable iff (!rstN)
    (abStrobe && abSel == 2'b11) |=> ##1 !stepN);

  a_r5_step_one_wide: assert property (@(posedge clk) disable iff (!rstN)
    !stepN |=> stepN);

  a_r6_dir_inverse: assert property (@(posedge clk) disable iff (!rstN)
    (abStrobe && abSel == 2'b11) |=> (dirOut == !$past(abData[5])));

  a_r4_other_codes_inert: assert property (@(posedge clk) disable iff (!rstN)
    !(abStrobe && abSel[0]) |=> ($stable(driveSel) && $stable(progOut) && $stable(headOut)));

  a_r7_floppy_forces: assert property (@(posedge clk) disable iff (!rstN)
    driveSel[0] |=> (statusOut[5] && statusOut[1]));

  a_r10_none_selected: assert property (@(posedge clk) disable iff (!rstN)
    (driveSel == 4'h0) |=> (statusOut == 8'h00));

  a_r12_flag_after_load: assert property (@(posedge clk) disable iff (!rstN)
    (abStrobe && abSel[0]) |=> ##1 statusValid);
endmodule

bind auxbus_latch auxbus_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .abData      (abData),
  .abSel       (abSel),
  .abStrobe    (abStrobe),
  .driveSel    (driveSel),
  .progOut     (progOut),
  .headOut     (headOut),
  .dirOut      (dirOut),
  .stepN       (stepN),
  .statusOut   (statusOut),
  .statusValid (statusValid)
);

// File: tb/auxbus_latch_bench.sv
module auxbus_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_HD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] abData = '0;
  logic [1:0] abSel = '0;
  logic abStrobe = 1'b0;
  logic idxIn = 0, trk0In = 0, wrProtIn = 0, faultIn = 0;
  logic [NUM_HD-1:0] hdPresent = '0;
  logic hdReadyIn = 0, hdSeekDoneIn = 0;
  logic [3:0] driveSel, progOut, headOut;
  logic wrCurOut, dirOut, stepN, statusValid;
  logic [7:0] statusOut;

  int nChk = 0;
  int nBad = 0;
  bit cmpEn = 0;
  bit wiggle = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  auxbus_latch #(.NUM_HD(NUM_HD)) u_auxbus_latch (
    .clk(clk), .rstN(rstN), .abData(abData), .abSel(abSel), .abStrobe(abStrobe),
    .idxIn(idxIn), .trk0In(trk0In), .wrProtIn(wrProtIn), .faultIn(faultIn),
    .hdPresent(hdPresent), .hdReadyIn(hdReadyIn), .hdSeekDoneIn(hdSeekDoneIn),
    .driveSel(driveSel), .progOut(progOut), .headOut(headOut), .wrCurOut(wrCurOut),
    .dirOut(dirOut), .stepN(stepN), .statusOut(statusOut), .statusValid(statusValid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, written from the requirements
  function automatic logic [7:0] refStatus(input logic [7:0] o1, input logic idx, input logic t0,
                                           input logic wp, input logic flt, input logic [NUM_HD-1:0] pres,
                                           input logic rdy, input logic skc);
    logic [7:0] s;
    int cnt;
    int unit;
    bit fitted;
    s = 8'h00;
    cnt = 0;
    unit = 0;
    for (int i = 0; i < NUM_HD; i++)
      if (o1[5+i]) begin cnt++; unit = i; end
    if (o1[4] || cnt == 1) begin
      s[6] = idx; s[4] = t0; s[2] = wp; s[0] = flt;
      fitted = (cnt == 1) && pres[unit];
      if (o1[4] || !fitted) begin s[5] = 1; s[1] = 1; end
      else begin s[5] = skc; s[1] = rdy; end
    end
    return s;
  endfunction

  logic [7:0] mOut1, mStatus;
  logic [3:0] mHead;
  logic mWcur, mDirBit, mFire, mPush, mStepN, mValid;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOut1 <= 0; mHead <= 0; mWcur <= 0; mDirBit <= 0;
      mFire <= 0; mPush <= 0; mStepN <= 1; mValid <= 0; mStatus <= 0;
    end else begin
      mStatus <= refStatus(mOut1, idxIn, trk0In, wrProtIn, faultIn, hdPresent, hdReadyIn, hdSeekDoneIn);
      mStepN  <= !mFire;
      mValid  <= mPush;
      mFire   <= abStrobe && abSel == 2'b11;
      mPush   <= abStrobe && abSel[0];
      if (abStrobe && abSel == 2'b01) mOut1 <= abData;
      if (abStrobe && abSel == 2'b11) begin
        mHead <= abData[3:0]; mWcur <= abData[6]; mDirBit <= abData[5];
      end
    end
  end

  always @(negedge clk) begin
    if (cmpEn && rstN) begin
      chk("R2", "driveSel", driveSel, mOut1[7:4]);
      chk("R2", "progOut", progOut, mOut1[3:0]);
      chk("R3", "head", headOut, mHead);
      chk("R3", "wrCur", wrCurOut, mWcur);
      chk("R6", "dir", dirOut, !mDirBit);
      chk("R5", "stepN", stepN, mStepN);
      chk("R11", "status", statusOut, mStatus);
      chk("R12", "valid", statusValid, mValid);
    end
  end

  always @(negedge clk) begin
    if (wiggle) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      {idxIn, trk0In, wrProtIn, faultIn} = seed[19:16];
      {hdReadyIn, hdSeekDoneIn} = seed[21:20];
      if (seed[27:24] == 0) hdPresent = seed[30:28];
    end
  end

  task automatic busWrite(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    abStrobe = 1; abSel = sel; abData = data;
    @(negedge clk);
    abStrobe = 0; abSel = 0; abData = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset values while held and after release
    chk("R1", "status in reset", statusOut, 8'h00);
    chk("R1", "stepN in reset", stepN, 1);
    rstN = 1;
    chk("R1", "driveSel", driveSel, 0);
    chk("R1", "head", headOut, 0);
    chk("R1", "dir", dirOut, 1);
    chk("R1", "valid", statusValid, 0);
    idle(1);
    chk("R1", "status after release", statusOut, 8'h00);
    cmpEn = 1;

    {idxIn, trk0In, wrProtIn, faultIn} = 4'hF;
    busWrite(2'b01, 8'h1A);
    chk("R2", "driveSel after load", driveSel, 4'h1);
    chk("R2", "progOut after load", progOut, 4'hA);
    idle(1);
    chk("R7", "floppy status", statusOut, 8'h77);
    chk("R8", "bits 7 and 3", statusOut & 8'h88, 0);
    chk("R12", "flag set", statusValid, 1);
    idle(1);
    chk("R12", "flag one cycle", statusValid, 0);

    busWrite(2'b11, 8'h65);
    chk("R3", "head", headOut, 5);
    chk("R3", "wrCur", wrCurOut, 1);
    chk("R6", "dir before step", dirOut, 0);
    chk("R5", "step not yet", stepN, 1);
    idle(1);
    chk("R5", "step low", stepN, 0);
    idle(1);
    chk("R5", "step released", stepN, 1);

    busWrite(2'b00, 8'hFF);
    idle(1);
    chk("R4", "no step code 00", stepN, 1);
    chk("R4", "no flag code 00", statusValid, 0);
    busWrite(2'b10, 8'h00);
    idle(1);
    chk("R4", "no step code 10", stepN, 1);
    chk("R4", "no flag code 10", statusValid, 0);
    chk("R4", "driveSel kept", driveSel, 4'h1);
    chk("R4", "progOut kept", progOut, 4'hA);
    chk("R4", "head kept", headOut, 5);
    chk("R4", "dir kept", dirOut, 0);

    {idxIn, trk0In, wrProtIn, faultIn} = 4'b0101;
    hdPresent = 3'b010; hdReadyIn = 0; hdSeekDoneIn = 1;
    busWrite(2'b01, 8'h43);
    idle(1);
    chk("R9", "unit1 fitted", statusOut, 8'h31);
    hdReadyIn = 1; hdSeekDoneIn = 0;
    idle(1);
    chk("R11", "line change latency", statusOut, 8'h13);
    hdPresent = 3'b101;
    idle(1);
    chk("R9", "unit1 absent", statusOut, 8'h33);
    busWrite(2'b01, 8'h60);
    idle(1);
    chk("R10", "two hd bits", statusOut, 8'h00);
    busWrite(2'b01, 8'h00);
    idle(1);
    chk("R10", "nothing selected", statusOut, 8'h00);
    busWrite(2'b01, 8'hF0);
    idle(1);
    chk("R7", "floppy over hd bits", statusOut, 8'h33);

    wiggle = 1;
    for (int i = 0; i < 300; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      busWrite(seed[9:8], seed[7:0]);
      idle(2 + seed[12:11]);
    end
    wiggle = 0;
    idle(4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule